// File: doc/BRIEF.md
# DRAM Rank Clock-Enable Power Sequencer

This block owns the clock-enable (CKE) pins of one DRAM channel, one pin per rank. It puts the channel into power-down when the command scheduler asks and brings it back out. It also runs the self-refresh exit sequence when software sets a start bit. While it does this it enforces the minimum CKE low and high pulse widths, the spacing between a power-down exit and the next non-read command, and the wait after a self-refresh exit. It gives the scheduler two ready lines, one for reads and one for all other commands.

A single 32-bit control word holds all of the timing fields, the per-rank population flags, the power-down enable and the self-refresh start bit. The control word is written through a plain write port and can be read back at any time. A CKE pin is driven high only when its rank is flagged as populated. Pins of unpopulated ranks stay low.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000800, every CKE pin is 0, and both ready outputs are 1.
- R2: Bits 31:28 and 15:14 of the control word always read 0, whatever is written to them.
- R3: Bits 23:20 flag ranks 3..0 as populated (1 = populated). A CKE pin is never 1 for a rank whose flag is 0. While the block is active, `cke` equals the flag vector.
- R4: While `pop_lock` is 1, a write leaves bits 23:20 unchanged. The other writable bits still take the written value.
- R5: With bit 16 at 0, `pd_req` has no effect: CKE stays equal to the flag vector and `rdy_nonread` stays 1.
- R6: With bit 16 at 1, `pd_req` sampled high drops all CKE pins at that clock edge, and both ready outputs are 0 while CKE is low. The low period lasts at least max(L,1) clocks, where L is bits 19:17. It lasts exactly that long when `pd_req` falls earlier.
- R7: A power-down or self-refresh entry waits until CKE has been high for max(H,1) clocks, where H is bits 26:24.
- R8: After CKE rises on a power-down exit, `rdy_nonread` stays 0 for exactly T clocks and `rdy_read` is 1 from the first high clock. T is set by bits 13:10; codes 2..9 give 2..9 clocks.
- R9: Code values 0 and 1 in bits 13:10 act as 2 clocks. Code values 10..15 act as 9 clocks.
- R10: Setting bit 27 starts a self-refresh exit. CKE goes low for max(L,1) clocks and then rises. Both ready outputs then stay 0 for max(N,1) clocks, where N is bits 9:1. After that, bit 27 reads 0.
- R11: Bit 0 (single module populated) is stored and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Value to write into the control word |
| pop_lock | input | 1 | Freezes the rank population flags |
| pd_req | input | 1 | Scheduler request to hold the channel in power-down |
| cfg_rd_data | output | 32 | Current control word |
| cke | output | 4 | Per-rank clock enable |
| rdy_nonread | output | 1 | A non-read command may issue this cycle |
| rdy_read | output | 1 | A read command may issue this cycle |

## Verification
The hardest behaviour to reach is the high-pulse hold-off. It only shows when a new power-down request arrives soon after an exit. The bench sets H above the exit spacing, re-raises `pd_req` on the very first high clock after an exit, and measures the high pulse. Reserved spacing codes and a zero self-refresh count are reached by writing those values directly. Each width is then counted cycle by cycle from falling-edge samples.

// File: rtl/cke_pkg.sv
// Shared field positions, state type and widths for the CKE power sequencer.
// Assumes the control-word layout is fixed; only counter widths are tunable.
package cke_pkg;
    localparam int RANKS      = 4;
    localparam int WORD_W     = 32;
    localparam int PULSE_W    = 3;
    localparam int SPACE_W    = 4;
    localparam int SREXIT_W   = 9;

    localparam int B_SRSTART  = 27;
    localparam int B_HI_LSB   = 24;
    localparam int B_POP_LSB  = 20;
    localparam int B_LO_LSB   = 17;
    localparam int B_PDEN     = 16;
    localparam int B_XP_LSB   = 10;
    localparam int B_SRX_LSB  = 1;

    localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0800;
    localparam logic [WORD_W-1:0] WRITE_MASK = 32'h0FFF_3FFF;
    localparam logic [WORD_W-1:0] POP_MASK   = 32'h00F0_0000;

    localparam int XP_MIN = 2;
    localparam int XP_MAX = 9;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_PDOWN,
        ST_PDEXIT,
        ST_SRLOW,
        ST_SRWAIT
    } cke_state_e;
endpackage

// File: rtl/cke_cfg_reg.sv
// Control word storage and field decode.
// Assumes one write per cycle; a write wins over the hardware clear of the
// self-refresh start bit in the same cycle.
module cke_cfg_reg
    import cke_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                pop_lock,
    input  logic                sr_done,
    output logic [WORD_W-1:0]   word_q,
    output logic                sr_start,
    output logic [PULSE_W-1:0]  min_hi,
    output logic [PULSE_W-1:0]  min_lo,
    output logic [RANKS-1:0]    pop,
    output logic                pd_en,
    output logic [SPACE_W-1:0]  xp_clks,
    output logic [SREXIT_W-1:0] srx_cnt
);
    logic [WORD_W-1:0]  word_d;
    logic [WORD_W-1:0]  masked;
    logic [SPACE_W-1:0] xp_code;

    // Next value of the word: masked write, locked flags, self-clear.
    always_comb begin
        masked = wr_data & WRITE_MASK;
        word_d = word_q;
        if (wr_en) begin
            word_d = pop_lock ? ((masked & ~POP_MASK) | (word_q & POP_MASK)) : masked;
        end else if (sr_done) begin
            word_d[B_SRSTART] = 1'b0;
        end
    end

    // Storage register.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= RESET_WORD;
        else        word_q <= word_d;
    end

    // Field extraction with clamping of reserved spacing codes.
    always_comb begin
        sr_start = word_q[B_SRSTART];
        min_hi   = word_q[B_HI_LSB  +: PULSE_W];
        min_lo   = word_q[B_LO_LSB  +: PULSE_W];
        pop      = word_q[B_POP_LSB +: RANKS];
        pd_en    = word_q[B_PDEN];
        srx_cnt  = word_q[B_SRX_LSB +: SREXIT_W];
        xp_code  = word_q[B_XP_LSB  +: SPACE_W];
        if (xp_code < SPACE_W'(XP_MIN))      xp_clks = SPACE_W'(XP_MIN);
        else if (xp_code > SPACE_W'(XP_MAX)) xp_clks = SPACE_W'(XP_MAX);
        else                                 xp_clks = xp_code;
    end
endmodule

// File: rtl/cke_dwell.sv
// Counts how long CKE has held its present level, saturating.
// Assumes toggle_nxt is asserted in the cycle whose edge changes the level.
module cke_dwell #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          toggle_nxt,
    input  logic [CW-1:0] min_hi,
    input  logic [CW-1:0] min_lo,
    output logic          may_toggle
);
    localparam logic [CW-1:0] SAT = '1;
    logic [CW-1:0] dwell;
    logic [CW:0]   held;
    logic [CW:0]   need;

    // Reset on a level change, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                dwell <= SAT;
        else if (toggle_nxt)       dwell <= '0;
        else if (dwell != SAT)     dwell <= dwell + 1'b1;
    end

    // Level may change at the end of this cycle once the minimum is met.
    always_comb begin
        held       = {1'b0, dwell} + 1'b1;
        need       = {1'b0, (level ? min_hi : min_lo)};
        may_toggle = (held >= need);
    end
endmodule

// File: rtl/cke_seq_fsm.sv
// Power-state sequencer: power-down entry/exit, self-refresh exit, ready lines.
// Assumes self-refresh exit requests take priority over power-down.
module cke_seq_fsm
    import cke_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_req,
    input  logic                pd_en,
    input  logic                sr_start,
    input  logic                may_toggle,
    input  logic [SPACE_W-1:0]  xp_clks,
    input  logic [SREXIT_W-1:0] srx_cnt,
    output logic                level,
    output logic                toggle_nxt,
    output logic                rdy_nonread,
    output logic                rdy_read,
    output logic                sr_done
);
    cke_state_e          state, state_d;
    logic [SREXIT_W-1:0] cnt, cnt_d;
    logic                level_d;

    // Next-state, counter load and completion pulse.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        sr_done = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                if (sr_start && may_toggle)             state_d = ST_SRLOW;
                else if (pd_en && pd_req && may_toggle) state_d = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (sr_start) begin
                    state_d = ST_SRLOW;
                end else if ((!pd_req || !pd_en) && may_toggle) begin
                    state_d = ST_PDEXIT;
                    cnt_d   = SREXIT_W'(xp_clks) - 1'b1;
                end
            end
            ST_PDEXIT: begin
                if (cnt == '0) state_d = ST_ACTIVE;
                else           cnt_d   = cnt - 1'b1;
            end
            ST_SRLOW: begin
                if (may_toggle) begin
                    state_d = ST_SRWAIT;
                    cnt_d   = (srx_cnt == '0) ? '0 : srx_cnt - 1'b1;
                end
            end
            ST_SRWAIT: begin
                if (cnt == '0) begin
                    state_d = ST_ACTIVE;
                    sr_done = 1'b1;
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // CKE level implied by the next state, and the toggle it causes.
    always_comb begin
        level_d    = !(state_d == ST_PDOWN || state_d == ST_SRLOW);
        toggle_nxt = (level_d != level);
    end

    // State, counter and CKE level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
            level <= 1'b1;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            level <= level_d;
        end
    end

    // Ready lines decoded from the registered state.
    always_comb begin
        rdy_nonread = (state == ST_ACTIVE);
        rdy_read    = (state == ST_ACTIVE) || (state == ST_PDEXIT);
    end
endmodule

// File: rtl/cke_pwr_ctrl.sv
// Top level: control word, dwell timer and sequencer for one channel's CKE pins.
// Assumes CKE is common in level across populated ranks.
module cke_pwr_ctrl
    import cke_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    input  logic              pop_lock,
    input  logic              pd_req,
    output logic [31:0]       cfg_rd_data,
    output logic [3:0]        cke,
    output logic              rdy_nonread,
    output logic              rdy_read
);
    logic                sr_start, sr_done, pd_en, level, toggle_nxt, may_toggle;
    logic [PULSE_W-1:0]  min_hi, min_lo;
    logic [RANKS-1:0]    pop;
    logic [SPACE_W-1:0]  xp_clks;
    logic [SREXIT_W-1:0] srx_cnt;

    cke_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
        .pop_lock(pop_lock), .sr_done(sr_done), .word_q(cfg_rd_data),
        .sr_start(sr_start), .min_hi(min_hi), .min_lo(min_lo), .pop(pop),
        .pd_en(pd_en), .xp_clks(xp_clks), .srx_cnt(srx_cnt)
    );

    cke_dwell #(.CW(PULSE_W)) u_dwell (
        .clk(clk), .rst_n(rst_n), .level(level), .toggle_nxt(toggle_nxt),
        .min_hi(min_hi), .min_lo(min_lo), .may_toggle(may_toggle)
    );

    cke_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_en(pd_en),
        .sr_start(sr_start), .may_toggle(may_toggle), .xp_clks(xp_clks),
        .srx_cnt(srx_cnt), .level(level), .toggle_nxt(toggle_nxt),
        .rdy_nonread(rdy_nonread), .rdy_read(rdy_read), .sr_done(sr_done)
    );

    // Drive CKE only on populated ranks.
    always_comb cke = pop & {RANKS{level}};
endmodule

// File: rtl/cke_pwr_chk.sv
// Port-level properties of the CKE sequencer, bound onto the top module.
module cke_pwr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic        pop_lock,
    input logic        pd_req,
    input logic [31:0] cfg_rd_data,
    input logic [3:0]  cke,
    input logic        rdy_nonread,
    input logic        rdy_read
);
    AST_CKE_ONLY_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cke & ~cfg_rd_data[23:20]) == 4'b0000); // R3

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[31:28] == 4'b0000 && cfg_rd_data[15:14] == 2'b00); // R2

    AST_LOCKED_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && pop_lock) |=> $stable(cfg_rd_data[23:20])); // R4

    AST_PD_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_data[16] && !cfg_rd_data[27] && !cfg_wr_en && cke == cfg_rd_data[23:20])
        |=> cke == cfg_rd_data[23:20]); // R5

    AST_NONREAD_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_nonread |-> rdy_read); // R8

    AST_LOW_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[23:20] != 4'b0000 && cke == 4'b0000) |-> (!rdy_read && !rdy_nonread)); // R6
endmodule

bind cke_pwr_ctrl cke_pwr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .pop_lock(pop_lock),
    .pd_req(pd_req), .cfg_rd_data(cfg_rd_data), .cke(cke),
    .rdy_nonread(rdy_nonread), .rdy_read(rdy_read)
);

// File: tb/cke_pwr_ctrl_tb_top.sv
// Directed bench for the CKE power sequencer; one task per scenario.
module cke_pwr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        pop_lock = 1'b0;
    logic        pd_req = 1'b0;
    logic [31:0] cfg_rd_data;
    logic [3:0]  cke;
    logic        rdy_nonread, rdy_read;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    cke_pwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .pop_lock(pop_lock), .pd_req(pd_req), .cfg_rd_data(cfg_rd_data), .cke(cke),
        .rdy_nonread(rdy_nonread), .rdy_read(rdy_read)
    );

    function automatic logic [31:0] mk_cfg(input logic sr, input int hi, input logic [3:0] pop,
                                           input int lo, input logic en, input int xp,
                                           input int srx, input logic single);
        logic [31:0] w;
        w = '0;
        w[27]    = sr;
        w[26:24] = 3'(hi);
        w[23:20] = pop;
        w[19:17] = 3'(lo);
        w[16]    = en;
        w[13:10] = 4'(xp);
        w[9:1]   = 9'(srx);
        w[0]     = single;
        return w;
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One short power-down pulse; returns low width and non-read hold-off.
    task automatic pd_pulse(output int lo, output int xp);
        @(negedge clk); pd_req = 1'b1;
        @(negedge clk); pd_req = 1'b0;
        check("R6 entry", cke == 4'b0 && !rdy_read && !rdy_nonread, int'(cke), 0);
        lo = 1;
        @(negedge clk);
        while (cke == 4'b0 && lo < 100) begin lo++; @(negedge clk); end
        check("R8 read ready at rise", rdy_read == 1'b1, int'(rdy_read), 1);
        xp = 0;
        while (!rdy_nonread && xp < 100) begin xp++; @(negedge clk); end
    endtask

    task automatic t_reset();
        check("R1 word", cfg_rd_data == 32'h0000_0800, int'(cfg_rd_data), 32'h800);
        check("R1 cke", cke == 4'b0, int'(cke), 0);
        check("R1 ready", rdy_read && rdy_nonread, int'({rdy_read, rdy_nonread}), 3);
    endtask

    task automatic t_fields();
        logic [31:0] w;
        w = mk_cfg(1'b0, 1, 4'b0101, 4, 1'b0, 5, 0, 1'b1);
        wr(w | 32'hF000_C000);
        check("R2 reserved zero", cfg_rd_data == w, int'(cfg_rd_data), int'(w));
        check("R11 single bit", cfg_rd_data[0] == 1'b1, int'(cfg_rd_data[0]), 1);
        check("R3 cke follows flags", cke == 4'b0101, int'(cke), 5);
        w = mk_cfg(1'b0, 1, 4'b0101, 4, 1'b0, 5, 0, 1'b0);
        wr(w);
        check("R11 single cleared", cfg_rd_data[0] == 1'b0, int'(cfg_rd_data[0]), 0);
    endtask

    task automatic t_lock();
        pop_lock = 1'b1;
        wr(mk_cfg(1'b0, 1, 4'b1111, 4, 1'b0, 6, 0, 1'b0));
        check("R4 flags held", cfg_rd_data[23:20] == 4'b0101, int'(cfg_rd_data[23:20]), 5);
        check("R4 other bits written", cfg_rd_data[13:10] == 4'd6, int'(cfg_rd_data[13:10]), 6);
        check("R4 cke unchanged", cke == 4'b0101, int'(cke), 5);
        pop_lock = 1'b0;
    endtask

    task automatic t_pd_disabled();
        int bad;
        bad = 0;
        pd_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cke != 4'b0101 || !rdy_nonread) bad++;
        end
        pd_req = 1'b0;
        check("R5 request ignored", bad == 0, bad, 0);
    endtask

    task automatic t_pd(input int code, input int exp_xp, input string tag);
        int lo, xp;
        wr(mk_cfg(1'b0, 1, 4'b0101, 4, 1'b1, code, 0, 1'b0));
        repeat (10) @(negedge clk);
        pd_pulse(lo, xp);
        check("R6 low width", lo == 4, lo, 4);
        check(tag, xp == exp_xp, xp, exp_xp);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_high_min();
        int hi;
        wr(mk_cfg(1'b0, 7, 4'b0101, 1, 1'b1, 2, 0, 1'b0));
        repeat (10) @(negedge clk);
        @(negedge clk); pd_req = 1'b1;
        @(negedge clk); pd_req = 1'b0;
        while (cke == 4'b0) @(negedge clk);
        pd_req = 1'b1;
        hi = 0;
        while (cke != 4'b0 && hi < 100) begin hi++; @(negedge clk); end
        check("R7 high width", hi == 7, hi, 7);
        pd_req = 1'b0;
        while (cke == 4'b0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_srexit(input int n, input int exp_blk);
        int lo, blk;
        wr(mk_cfg(1'b1, 1, 4'b1111, 3, 1'b0, 2, n, 1'b0));
        @(negedge clk);
        lo = 0;
        while (cke == 4'b0 && lo < 100) begin lo++; @(negedge clk); end
        check("R10 low width", lo == 3, lo, 3);
        check("R10 cke rises", cke == 4'b1111, int'(cke), 15);
        blk = 0;
        while (!rdy_read && blk < 1000) begin blk++; @(negedge clk); end
        check("R10 block count", blk == exp_blk, blk, exp_blk);
        check("R10 start cleared", cfg_rd_data[27] == 1'b0, int'(cfg_rd_data[27]), 0);
        check("R10 nonread ready", rdy_nonread == 1'b1, int'(rdy_nonread), 1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_lock();
        t_pd_disabled();
        t_pd(5, 5, "R8 spacing");
        t_pd(0, 2, "R9 low code clamp");
        t_pd(15, 9, "R9 high code clamp");
        t_high_min();
        t_srexit(10, 10);
        t_srexit(0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule